// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address and transfer-count datapath of one DMA channel. It keeps two 24-bit address pointers, one for each device side (A and B). Each pointer has a reload register that holds the start address of the next block. A 16-bit block counter tracks how many transfers remain in the current block. A control word sets three things: which side is the source, how each side's pointer moves after a transfer, and whether the transfer is one byte or two. A flyby setting uses side A alone.

Software programs the channel through a 32-bit register port. The bus engine pulses `xfer_done` once for each completed transfer. The block then presents the next source and destination addresses and the transfer size. On the final transfer of a block it raises `blk_done` and reloads the pointers and the count for the next block.

Top module: `dma_addr_engine`

## Requirements
- R1: Reset clears every register, so all reads and all outputs are zero.
- R2: The two current-pointer registers (side A at byte offset 0x00, side B at 0x08) hold 24 bits. Bits 31:24 read as zero, and writes to those bits have no effect.
- R3: The two reload registers (side A at 0x04, side B at 0x0C) hold 24 bits. Bits 31:24 read as zero.
- R4: In the control register at 0x1C, bit 0 selects the direction. When it is 0, side A is the source and side B the destination. When it is 1, side B is the source and side A the destination.
- R5: The control register layout is: bit 3 enables side A stepping and bits 5:4 are side A's step field; bit 6 enables side B stepping and bits 8:7 are side B's step field. Step code 01 adds the size, 10 subtracts it, and 00 or 11 leaves the pointer unchanged. A disabled side never steps. Pointers wrap modulo 2^24.
- R6: Control bit 1 selects the transfer size: 0 means 1 byte and 1 means 2 bytes. This sets the step magnitude and drives `xfer_two_byte`.
- R7: Control bit 2 selects flyby. In flyby, the side B pointer changes neither on a transfer nor at block end, and the address output that side B would drive reads zero.
- R8: The block counter (0x10) decrements by one on each `xfer_done`.
- R9: A block counter value of 0x0000 yields 65535 transfers before `blk_done`.
- R10: `blk_done` is high in the cycle of the transfer that finds the counter at 1. On that edge, each used pointer loads its reload register and the counter loads the block reload register (0x14).
- R11: Reads of undefined offsets return zero. The control register reads back only its nine defined bits.
- R12: A register write in the same cycle as a transfer takes priority over that transfer's update of the written register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| xfer_done | input | 1 | One pulse per completed transfer |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| xfer_two_byte | output | 1 | High for 2-byte transfers |
| blk_done | output | 1 | High during the final transfer of a block |

## Verification
The assertions check the per-cycle rules on every cycle:
- the block counter decrements by one and takes the 0x0000 case correctly;
- the counter reloads when `blk_done` is high;
- side B holds under flyby;
- a pointer with stepping disabled stays put between block ends.

The bench scenarios cover what needs whole sequences:
- address sequences under each direction, size and step code;
- wrap of the 24-bit pointers;
- the register map and its masked upper bits;
- the exact count of 65535 transfers for a zero block length.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_A_CUR = 5'h00;
  localparam logic [REG_AW-1:0] OFS_A_RLD = 5'h04;
  localparam logic [REG_AW-1:0] OFS_B_CUR = 5'h08;
  localparam logic [REG_AW-1:0] OFS_B_RLD = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CNT   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_CRLD  = 5'h14;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h1C;

  localparam int CTRL_BITS = 9;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_RSV  = 2'b11
  } step_e;

  typedef struct packed {
    logic [1:0] step_b;
    logic       adj_b;
    logic [1:0] step_a;
    logic       adj_a;
    logic       flyby;
    logic       two_byte;
    logic       dir;
  } ctrl_t;

  // Pointer adjustment after one transfer.
  function automatic logic [23:0] step_addr(input logic [23:0] cur,
                                            input logic en,
                                            input logic [1:0] code,
                                            input logic two_byte);
    logic [23:0] amt;
    amt = two_byte ? 24'd2 : 24'd1;
    if (!en) return cur;
    case (step_e'(code))
      STEP_UP:   return cur + amt;
      STEP_DOWN: return cur - amt;
      default:   return cur;
    endcase
  endfunction

  // Count after a transfer that is not the last of the block.
  // A zero count behaves like the largest value.
  function automatic logic [15:0] count_next(input logic [15:0] cnt);
    if (cnt == '0) return 16'hFFFE;
    return cnt - 16'd1;
  endfunction

endpackage

// File: rtl/dma_ptr_side.sv
module dma_ptr_side #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cur,
  input  logic          wr_rld,
  input  logic [AW-1:0] wdata,
  input  logic          xfer,
  input  logic          blk_end,
  input  logic          hold,
  input  logic          adj_en,
  input  logic [1:0]    step_code,
  input  logic          two_byte,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] rld
);
  import dma_eng_pkg::*;

  logic          upd_evt;
  logic [AW-1:0] stepped;

  assign upd_evt = xfer && !hold && !wr_cur;
  assign stepped = AW'(step_addr(24'(cur), adj_en, step_code, two_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (wr_cur) begin
      cur <= wdata;
    end else if (upd_evt) begin
      cur <= blk_end ? rld : stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld <= '0;
    else if (wr_rld) rld <= wdata;
  end

  // R7
  hold_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && hold && !wr_cur) |=> $stable(cur));

  // R5
  no_step_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !blk_end && !adj_en && !wr_cur) |=> $stable(cur));

  // R10
  reload_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && blk_end && !hold && !wr_cur && !wr_rld) |=> (cur == $past(rld)));

endmodule

// File: rtl/dma_blk_count.sv
module dma_blk_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic [CW-1:0] wdata,
  input  logic          xfer,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output logic          last
);
  import dma_eng_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  assign last = xfer && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= wdata;
    end else if (xfer) begin
      cnt <= last ? rld : CW'(count_next(16'(cnt)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld <= '0;
    else if (wr_rld) rld <= wdata;
  end

  // R8
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_cnt && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_cnt && cnt == '0) |=> (cnt == {CW{1'b1}} - ONE));

  // R10
  count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !wr_cnt && !wr_rld) |=> (cnt == $past(rld)));

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine #(
  parameter int DW = 32,
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [dma_eng_pkg::REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  output logic [DW-1:0]               reg_rdata,
  input  logic                        xfer_done,
  output logic [AW-1:0]               src_addr,
  output logic [AW-1:0]               dst_addr,
  output logic                        xfer_two_byte,
  output logic                        blk_done
);
  import dma_eng_pkg::*;

  localparam int NSIDE = 2;
  localparam int APAD  = DW - AW;
  localparam int CPAD  = DW - CW;
  localparam int KPAD  = DW - CTRL_BITS;

  ctrl_t         ctrl;
  logic          wr_ctrl;
  logic [AW-1:0] cur [NSIDE];
  logic [AW-1:0] rld [NSIDE];
  logic [CW-1:0] cnt_q, cnt_rld;
  logic          last_xfer;
  logic [AW-1:0] b_visible;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam logic [REG_AW-1:0] CUR_OFS = (g == 0) ? OFS_A_CUR : OFS_B_CUR;
    localparam logic [REG_AW-1:0] RLD_OFS = (g == 0) ? OFS_A_RLD : OFS_B_RLD;
    logic       hold_s, adj_s;
    logic [1:0] step_s;
    if (g == 0) begin : g_a
      assign hold_s = 1'b0;
      assign adj_s  = ctrl.adj_a;
      assign step_s = ctrl.step_a;
    end else begin : g_b
      assign hold_s = ctrl.flyby;
      assign adj_s  = ctrl.adj_b;
      assign step_s = ctrl.step_b;
    end
    dma_ptr_side #(.AW(AW)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cur    (reg_we && reg_addr == CUR_OFS),
      .wr_rld    (reg_we && reg_addr == RLD_OFS),
      .wdata     (reg_wdata[AW-1:0]),
      .xfer      (xfer_done),
      .blk_end   (last_xfer),
      .hold      (hold_s),
      .adj_en    (adj_s),
      .step_code (step_s),
      .two_byte  (ctrl.two_byte),
      .cur       (cur[g]),
      .rld       (rld[g])
    );
  end

  dma_blk_count #(.CW(CW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_cnt (reg_we && reg_addr == OFS_CNT),
    .wr_rld (reg_we && reg_addr == OFS_CRLD),
    .wdata  (reg_wdata[CW-1:0]),
    .xfer   (xfer_done),
    .cnt    (cnt_q),
    .rld    (cnt_rld),
    .last   (last_xfer)
  );

  assign b_visible     = ctrl.flyby ? '0 : cur[1];
  assign src_addr      = ctrl.dir ? b_visible : cur[0];
  assign dst_addr      = ctrl.dir ? cur[0] : b_visible;
  assign xfer_two_byte = ctrl.two_byte;
  assign blk_done      = last_xfer;

  always_comb begin
    case (reg_addr)
      OFS_A_CUR: reg_rdata = {{APAD{1'b0}}, cur[0]};
      OFS_A_RLD: reg_rdata = {{APAD{1'b0}}, rld[0]};
      OFS_B_CUR: reg_rdata = {{APAD{1'b0}}, cur[1]};
      OFS_B_RLD: reg_rdata = {{APAD{1'b0}}, rld[1]};
      OFS_CNT:   reg_rdata = {{CPAD{1'b0}}, cnt_q};
      OFS_CRLD:  reg_rdata = {{CPAD{1'b0}}, cnt_rld};
      OFS_CTRL:  reg_rdata = {{KPAD{1'b0}}, ctrl};
      default:   reg_rdata = '0;
    endcase
  end

  // R7
  flyby_b_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.flyby |-> (ctrl.dir ? (src_addr == '0) : (dst_addr == '0)));

  // R11
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 5'h18) |-> (reg_rdata == '0));

endmodule

// File: tb/dma_addr_engine_test.sv
module dma_addr_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_done = 1'b0;
  logic [23:0] src_addr, dst_addr;
  logic        xfer_two_byte, blk_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_addr_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_two_byte(xfer_two_byte), .blk_done(blk_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] cw(bit dir, bit two, bit fly, bit ea,
                                     logic [1:0] sa, bit eb, logic [1:0] sb);
    return {23'd0, sb, eb, sa, ea, fly, two, dir};
  endfunction

  task automatic pulse(output logic done_seen);
    xfer_done = 1'b1; #1; done_seen = blk_done;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset src", {8'h0, src_addr}, 32'h0);
    check("R1 reset blk_done", {31'h0, blk_done}, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(5'h00, 32'hFFABCDEF); rd(5'h00, d); check("R2 A cur upper", d, 32'h00ABCDEF);
    wr(5'h08, 32'h12345678); rd(5'h08, d); check("R2 B cur upper", d, 32'h00345678);
    wr(5'h04, 32'hFF123456); rd(5'h04, d); check("R3 A reload", d, 32'h00123456);
    wr(5'h0C, 32'hA0654321); rd(5'h0C, d); check("R3 B reload", d, 32'h00654321);
    rd(5'h18, d); check("R11 undefined 18", d, 32'h0);
    rd(5'h02, d); check("R11 undefined 02", d, 32'h0);
    wr(5'h1C, 32'hFFFFFFFF); rd(5'h1C, d); check("R11 ctrl readback", d, 32'h1FF);
    wr(5'h1C, 32'h0);
  endtask

  task automatic t_direction;
    wr(5'h00, 32'h100); wr(5'h08, 32'h200);
    wr(5'h1C, cw(0, 0, 0, 0, 0, 0, 0));
    check("R4 dir0 src", {8'h0, src_addr}, 32'h100);
    check("R4 dir0 dst", {8'h0, dst_addr}, 32'h200);
    wr(5'h1C, cw(1, 0, 0, 0, 0, 0, 0));
    check("R4 dir1 src", {8'h0, src_addr}, 32'h200);
    check("R4 dir1 dst", {8'h0, dst_addr}, 32'h100);
  endtask

  task automatic t_steps;
    logic b;
    logic [31:0] d;
    wr(5'h10, 32'd100); wr(5'h14, 32'd100);
    wr(5'h00, 32'h100); wr(5'h08, 32'h200);
    wr(5'h1C, cw(0, 0, 0, 1, 2'b01, 1, 2'b10));
    check("R6 size1 out", {31'h0, xfer_two_byte}, 32'h0);
    repeat (3) pulse(b);
    check("R5 A +1 x3", {8'h0, src_addr}, 32'h103);
    check("R5 B -1 x3", {8'h0, dst_addr}, 32'h1FD);
    rd(5'h10, d); check("R8 count 97", d, 32'd97);
    wr(5'h1C, cw(0, 1, 0, 1, 2'b01, 1, 2'b10));
    check("R6 size2 out", {31'h0, xfer_two_byte}, 32'h1);
    repeat (2) pulse(b);
    check("R6 A +2 x2", {8'h0, src_addr}, 32'h107);
    check("R6 B -2 x2", {8'h0, dst_addr}, 32'h1F9);
    wr(5'h1C, cw(1, 1, 0, 1, 2'b11, 1, 2'b00));
    pulse(b);
    check("R5 code11 A", {8'h0, dst_addr}, 32'h107);
    check("R5 code00 B", {8'h0, src_addr}, 32'h1F9);
    wr(5'h1C, cw(0, 0, 0, 0, 2'b01, 0, 2'b01));
    pulse(b);
    check("R5 disabled A", {8'h0, src_addr}, 32'h107);
    check("R5 disabled B", {8'h0, dst_addr}, 32'h1F9);
    wr(5'h00, 32'hFFFFFF); wr(5'h08, 32'h0);
    wr(5'h1C, cw(0, 0, 0, 1, 2'b01, 1, 2'b10));
    pulse(b);
    check("R5 A wrap up", {8'h0, src_addr}, 32'h0);
    check("R5 B wrap down", {8'h0, dst_addr}, 32'hFFFFFF);
  endtask

  task automatic t_block;
    logic b;
    logic [31:0] d;
    wr(5'h1C, cw(0, 0, 0, 1, 2'b01, 1, 2'b01));
    wr(5'h00, 32'h10); wr(5'h08, 32'h20);
    wr(5'h04, 32'h500); wr(5'h0C, 32'h600);
    wr(5'h10, 32'd3); wr(5'h14, 32'd5);
    pulse(b); check("R10 no done 1", {31'h0, b}, 32'h0);
    rd(5'h10, d); check("R8 count 2", d, 32'd2);
    pulse(b); check("R10 no done 2", {31'h0, b}, 32'h0);
    pulse(b); check("R10 done on last", {31'h0, b}, 32'h1);
    #1; check("R10 done one cycle", {31'h0, blk_done}, 32'h0);
    rd(5'h10, d); check("R10 count reload", d, 32'd5);
    check("R10 A reload", {8'h0, src_addr}, 32'h500);
    check("R10 B reload", {8'h0, dst_addr}, 32'h600);
    // R12: write and transfer in the same cycle
    reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h777; xfer_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; xfer_done = 1'b0;
    check("R12 write wins", {8'h0, src_addr}, 32'h777);
    check("R12 other side steps", {8'h0, dst_addr}, 32'h601);
  endtask

  task automatic t_flyby;
    logic b;
    logic [31:0] d;
    wr(5'h00, 32'h300); wr(5'h08, 32'h700);
    wr(5'h04, 32'h900); wr(5'h0C, 32'h800);
    wr(5'h10, 32'd2); wr(5'h14, 32'd4);
    wr(5'h1C, cw(0, 0, 1, 1, 2'b01, 1, 2'b01));
    check("R7 dst hidden", {8'h0, dst_addr}, 32'h0);
    pulse(b);
    pulse(b); check("R7 block end seen", {31'h0, b}, 32'h1);
    rd(5'h08, d); check("R7 B held", d, 32'h700);
    check("R7 A reloaded", {8'h0, src_addr}, 32'h900);
    wr(5'h1C, cw(1, 0, 1, 1, 2'b01, 1, 2'b01));
    check("R7 src hidden dir1", {8'h0, src_addr}, 32'h0);
  endtask

  task automatic t_zero_len;
    int early = 0;
    logic b;
    wr(5'h1C, cw(0, 0, 0, 0, 0, 0, 0));
    wr(5'h10, 32'h0); wr(5'h14, 32'h0);
    xfer_done = 1'b1;
    for (int i = 1; i < 65535; i++) begin
      #1; if (blk_done) early++;
      @(negedge clk);
    end
    #1; b = blk_done;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R9 no early done", early, 0);
    check("R9 done at 65535", {31'h0, b}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_regmap;
    t_direction;
    t_steps;
    t_block;
    t_flyby;
    t_zero_len;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule